// File: doc/BRIEF.md
# Interrupt Entry and Priority Sequencer

This block is the part of a 16-bit real-mode processor that decides, at each instruction boundary, whether an interrupt is taken, which one wins, and then runs the bus transfers that enter or leave a handler. Requests come from three places. Internal exceptions arrive as pulses with the boundary: a divide fault, a software interrupt with its own 8-bit type, and the overflow trap. There is an NMI pin that reacts to a rising edge. There is also a level-sensitive INTR pin that supplies its own type number through an acknowledge handshake. Single stepping is requested when the trap flag was set at the start of the instruction that has just completed.

Once a source is accepted, the sequencer takes a snapshot of FLAGS, CS, IP and SP and runs a fixed sequence. For INTR only, it first runs two acknowledge cycles. It then performs three stack writes, reads two words from the vector table and presents the new CS:IP, SP and FLAGS with a one-cycle `load` strobe. A return request pops IP, CS and FLAGS from the stack and presents them the same way. Each bus transfer takes exactly one cycle. Read data is taken in the cycle it is requested.

The states are IDLE, ACK_FIRST, ACK_SECOND, PUSH_FLAGS, PUSH_CS, PUSH_IP, VEC_LO, VEC_HI, POP_IP, POP_CS, POP_FLAGS and LOAD. The transitions are as follows. IDLE goes to POP_IP on a return request. Otherwise, IDLE goes to ACK_FIRST when INTR wins, or to PUSH_FLAGS when any other source wins. ACK_FIRST goes to ACK_SECOND, and ACK_SECOND goes to PUSH_FLAGS. The three pushes follow one another, then VEC_LO, then VEC_HI, then LOAD. POP_IP goes to POP_CS, then POP_FLAGS, then LOAD. LOAD always returns to IDLE.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `bus_wr`, `bus_rd`, `bus_inta`, `bus_lock` and `load` are all low.
- R2: At a boundary (`instr_done` high in IDLE), the winner is chosen in this order: an internal exception first (divide, then software interrupt, then overflow trap), then a pending NMI, then INTR, then single step.
- R3: The divide fault uses type 0, NMI type 2 and the overflow trap type 4. A software interrupt uses `swi_type`. When `exc_into` arrives with `of_flag` low, no entry starts and the bus stays idle.
- R4: A rising edge on `nmi_pin` is latched and stays pending until NMI is taken. An edge that arrives while another entry is running is kept and is taken at a later boundary.
- R5: INTR is taken only when `intr_pin` is high and IF (`flags_in` bit 9) is 1 at the boundary. Otherwise it is ignored and causes no bus activity.
- R6: INTR acceptance starts with exactly two consecutive `bus_inta` cycles, with `bus_lock` high in both. The type is taken from `inta_data` in the second cycle.
- R7: Entry writes, in this order, FLAGS to SS:SP-2, CS to SS:SP-4 and IP to SS:SP-6. The physical address is SS×16 plus the offset.
- R8: After the pushes, IP is read from physical address type×4 and CS from type×4+2. `load` then presents those values on `ip_out` and `cs_out` and the type on `vec_type`. Type FFH reads 003FCH and 003FEH.
- R9: At entry `load`, `sp_out` equals SP-6. `flags_out` is the saved FLAGS with IF (bit 9) and TF (bit 8) cleared. The FLAGS word pushed to the stack keeps both bits.
- R10: Single step (type 1) is taken when `tf_at_start` is high and no other source wins, including when INTR is masked.
- R11: `iret_req` in IDLE reads IP from SS:SP, CS from SS:SP+2 and FLAGS from SS:SP+4. It then raises `load` with those values and `sp_out` = SP+6.
- R12: `instr_done` and `iret_req` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | Instruction boundary pulse |
| exc_div | input | 1 | Divide fault with this boundary |
| exc_swi | input | 1 | Software interrupt with this boundary |
| swi_type | input | 8 | Type of the software interrupt |
| exc_into | input | 1 | Overflow trap instruction completed |
| of_flag | input | 1 | Overflow flag for the trap instruction |
| tf_at_start | input | 1 | TF as it was when the instruction began |
| nmi_pin | input | 1 | Edge-sensitive non-maskable request |
| intr_pin | input | 1 | Level-sensitive maskable request |
| iret_req | input | 1 | Return-from-interrupt request |
| flags_in | input | 16 | Current FLAGS |
| cs_in | input | 16 | Current CS |
| ip_in | input | 16 | Return IP |
| sp_in | input | 16 | Current SP |
| ss_in | input | 16 | Stack segment |
| rd_data | input | 16 | Memory read data, same cycle |
| inta_data | input | 8 | Low data byte during acknowledge |
| busy | output | 1 | Sequence in progress |
| bus_wr | output | 1 | Memory write strobe |
| bus_rd | output | 1 | Memory read strobe |
| bus_inta | output | 1 | Interrupt acknowledge strobe |
| bus_lock | output | 1 | Bus lock during acknowledge |
| bus_addr | output | 20 | Physical address |
| wr_data | output | 16 | Write data |
| load | output | 1 | New register values valid |
| cs_out | output | 16 | New CS |
| ip_out | output | 16 | New IP |
| sp_out | output | 16 | New SP |
| flags_out | output | 16 | New FLAGS |
| vec_type | output | 8 | Type that was serviced |

## Verification
Two situations can make two functions act in the same cycle.

The first is an NMI edge arriving while an entry is in progress. The NMI latch must set on that edge while the sequencer is busy with another entry. The bench raises `nmi_pin` in the middle of a software-interrupt entry. It then checks that the entry finishes with its own type, and that the next bare boundary enters type 2.

The second is a boundary pulse arriving during an entry. The bench pulses `instr_done` with a software interrupt while a divide entry is still pushing. It then checks that exactly five bus transfers occurred and that `vec_type` is still 0.

Priority collisions are covered by table rows that raise several sources at once and compare the serviced type and the whole bus transcript.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ACK_FIRST,
        S_ACK_SECOND,
        S_PUSH_FLAGS,
        S_PUSH_CS,
        S_PUSH_IP,
        S_VEC_LO,
        S_VEC_HI,
        S_POP_IP,
        S_POP_CS,
        S_POP_FLAGS,
        S_LOAD
    } seq_state_t;

    localparam int IF_BIT = 9;
    localparam int TF_BIT = 8;

    localparam int TYPE_DIV  = 0;
    localparam int TYPE_STEP = 1;
    localparam int TYPE_NMI  = 2;
    localparam int TYPE_OVF  = 4;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic              nmi_take,
    input  logic              exc_div,
    input  logic              exc_swi,
    input  logic [TYPE_W-1:0] swi_type,
    input  logic              exc_into,
    input  logic              of_flag,
    input  logic              intr_pin,
    input  logic              if_flag,
    input  logic              tf_at_start,
    output logic              win_valid,
    output logic [TYPE_W-1:0] win_type,
    output logic              win_inta,
    output logic              win_nmi
);

    logic nmi_q;
    logic nmi_pend;
    logic nmi_rise;

    assign nmi_rise = nmi_pin & ~nmi_q;

    // Edge latch: a new edge in the same cycle as the take keeps it pending.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q    <= nmi_pin;
            nmi_pend <= (nmi_pend & ~nmi_take) | nmi_rise;
        end
    end

    always_comb begin
        win_valid = 1'b0;
        win_type  = '0;
        win_inta  = 1'b0;
        win_nmi   = 1'b0;
        if (exc_div) begin
            win_valid = 1'b1;
            win_type  = TYPE_W'(TYPE_DIV);
        end else if (exc_swi) begin
            win_valid = 1'b1;
            win_type  = swi_type;
        end else if (exc_into && of_flag) begin
            win_valid = 1'b1;
            win_type  = TYPE_W'(TYPE_OVF);
        end else if (nmi_pend) begin
            win_valid = 1'b1;
            win_type  = TYPE_W'(TYPE_NMI);
            win_nmi   = 1'b1;
        end else if (intr_pin && if_flag) begin
            win_valid = 1'b1;
            win_inta  = 1'b1;
        end else if (tf_at_start) begin
            win_valid = 1'b1;
            win_type  = TYPE_W'(TYPE_STEP);
        end
    end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 20,
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic              iret_req,
    input  logic              win_valid,
    input  logic [TYPE_W-1:0] win_type,
    input  logic              win_inta,
    input  logic [WORD_W-1:0] flags_in,
    input  logic [WORD_W-1:0] cs_in,
    input  logic [WORD_W-1:0] ip_in,
    input  logic [WORD_W-1:0] sp_in,
    input  logic [WORD_W-1:0] ss_in,
    input  logic [WORD_W-1:0] rd_data,
    input  logic [TYPE_W-1:0] inta_data,
    output logic              accept,
    output logic              busy,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic              bus_inta,
    output logic              bus_lock,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              load,
    output logic [WORD_W-1:0] cs_out,
    output logic [WORD_W-1:0] ip_out,
    output logic [WORD_W-1:0] sp_out,
    output logic [WORD_W-1:0] flags_out,
    output logic [TYPE_W-1:0] vec_type
);

    localparam int SEG_SHIFT = ADDR_W - WORD_W;
    localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

    seq_state_t state, state_nx;

    logic [WORD_W-1:0] flags_r, cs_r, ip_r, sp_r;
    logic [TYPE_W-1:0] type_r;
    logic [ADDR_W-1:0] vec_base;

    function automatic logic [ADDR_W-1:0] phys(input logic [WORD_W-1:0] seg,
                                                input logic [WORD_W-1:0] off);
        return ADDR_W'({seg, {SEG_SHIFT{1'b0}}}) + ADDR_W'(off);
    endfunction

    assign vec_base = ADDR_W'({type_r, 2'b00});
    assign accept   = (state == S_IDLE) && !iret_req && instr_done && win_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (iret_req)          state_nx = S_POP_IP;
                else if (accept)       state_nx = win_inta ? S_ACK_FIRST : S_PUSH_FLAGS;
            end
            S_ACK_FIRST:  state_nx = S_ACK_SECOND;
            S_ACK_SECOND: state_nx = S_PUSH_FLAGS;
            S_PUSH_FLAGS: state_nx = S_PUSH_CS;
            S_PUSH_CS:    state_nx = S_PUSH_IP;
            S_PUSH_IP:    state_nx = S_VEC_LO;
            S_VEC_LO:     state_nx = S_VEC_HI;
            S_VEC_HI:     state_nx = S_LOAD;
            S_POP_IP:     state_nx = S_POP_CS;
            S_POP_CS:     state_nx = S_POP_FLAGS;
            S_POP_FLAGS:  state_nx = S_LOAD;
            S_LOAD:       state_nx = S_IDLE;
            default:      state_nx = S_IDLE;
        endcase
    end

    // Snapshot and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_r <= '0;
            cs_r    <= '0;
            ip_r    <= '0;
            sp_r    <= '0;
            type_r  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (iret_req) begin
                        sp_r <= sp_in;
                    end else if (accept) begin
                        type_r  <= win_type;
                        flags_r <= flags_in;
                        cs_r    <= cs_in;
                        ip_r    <= ip_in;
                        sp_r    <= sp_in;
                    end
                end
                S_ACK_FIRST: ;
                S_ACK_SECOND: type_r <= inta_data;
                S_PUSH_FLAGS: begin
                    sp_r            <= sp_r - STEP;
                    flags_r[IF_BIT] <= 1'b0;
                    flags_r[TF_BIT] <= 1'b0;
                end
                S_PUSH_CS:   sp_r <= sp_r - STEP;
                S_PUSH_IP:   sp_r <= sp_r - STEP;
                S_VEC_LO:    ip_r <= rd_data;
                S_VEC_HI:    cs_r <= rd_data;
                S_POP_IP: begin
                    ip_r <= rd_data;
                    sp_r <= sp_r + STEP;
                end
                S_POP_CS: begin
                    cs_r <= rd_data;
                    sp_r <= sp_r + STEP;
                end
                S_POP_FLAGS: begin
                    flags_r <= rd_data;
                    sp_r    <= sp_r + STEP;
                end
                S_LOAD: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        bus_wr   = 1'b0;
        bus_rd   = 1'b0;
        bus_inta = 1'b0;
        bus_lock = 1'b0;
        bus_addr = '0;
        wr_data  = '0;
        load     = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_ACK_FIRST, S_ACK_SECOND: begin
                bus_inta = 1'b1;
                bus_lock = 1'b1;
            end
            S_PUSH_FLAGS: begin
                bus_wr   = 1'b1;
                bus_addr = phys(ss_in, sp_r - STEP);
                wr_data  = flags_r;
            end
            S_PUSH_CS: begin
                bus_wr   = 1'b1;
                bus_addr = phys(ss_in, sp_r - STEP);
                wr_data  = cs_r;
            end
            S_PUSH_IP: begin
                bus_wr   = 1'b1;
                bus_addr = phys(ss_in, sp_r - STEP);
                wr_data  = ip_r;
            end
            S_VEC_LO: begin
                bus_rd   = 1'b1;
                bus_addr = vec_base;
            end
            S_VEC_HI: begin
                bus_rd   = 1'b1;
                bus_addr = vec_base + ADDR_W'(2);
            end
            S_POP_IP, S_POP_CS, S_POP_FLAGS: begin
                bus_rd   = 1'b1;
                bus_addr = phys(ss_in, sp_r);
            end
            S_LOAD: load = 1'b1;
            default: ;
        endcase
    end

    assign busy      = (state != S_IDLE);
    assign cs_out    = cs_r;
    assign ip_out    = ip_r;
    assign sp_out    = sp_r;
    assign flags_out = flags_r;
    assign vec_type  = type_r;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 20,
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic              exc_div,
    input  logic              exc_swi,
    input  logic [TYPE_W-1:0] swi_type,
    input  logic              exc_into,
    input  logic              of_flag,
    input  logic              tf_at_start,
    input  logic              nmi_pin,
    input  logic              intr_pin,
    input  logic              iret_req,
    input  logic [WORD_W-1:0] flags_in,
    input  logic [WORD_W-1:0] cs_in,
    input  logic [WORD_W-1:0] ip_in,
    input  logic [WORD_W-1:0] sp_in,
    input  logic [WORD_W-1:0] ss_in,
    input  logic [WORD_W-1:0] rd_data,
    input  logic [TYPE_W-1:0] inta_data,
    output logic              busy,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic              bus_inta,
    output logic              bus_lock,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              load,
    output logic [WORD_W-1:0] cs_out,
    output logic [WORD_W-1:0] ip_out,
    output logic [WORD_W-1:0] sp_out,
    output logic [WORD_W-1:0] flags_out,
    output logic [TYPE_W-1:0] vec_type
);

    logic              win_valid;
    logic [TYPE_W-1:0] win_type;
    logic              win_inta;
    logic              win_nmi;
    logic              accept;

    irq_arbiter #(.TYPE_W(TYPE_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_pin     (nmi_pin),
        .nmi_take    (accept & win_nmi),
        .exc_div     (exc_div),
        .exc_swi     (exc_swi),
        .swi_type    (swi_type),
        .exc_into    (exc_into),
        .of_flag     (of_flag),
        .intr_pin    (intr_pin),
        .if_flag     (flags_in[IF_BIT]),
        .tf_at_start (tf_at_start),
        .win_valid   (win_valid),
        .win_type    (win_type),
        .win_inta    (win_inta),
        .win_nmi     (win_nmi)
    );

    irq_seq_fsm #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .iret_req   (iret_req),
        .win_valid  (win_valid),
        .win_type   (win_type),
        .win_inta   (win_inta),
        .flags_in   (flags_in),
        .cs_in      (cs_in),
        .ip_in      (ip_in),
        .sp_in      (sp_in),
        .ss_in      (ss_in),
        .rd_data    (rd_data),
        .inta_data  (inta_data),
        .accept     (accept),
        .busy       (busy),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_inta   (bus_inta),
        .bus_lock   (bus_lock),
        .bus_addr   (bus_addr),
        .wr_data    (wr_data),
        .load       (load),
        .cs_out     (cs_out),
        .ip_out     (ip_out),
        .sp_out     (sp_out),
        .flags_out  (flags_out),
        .vec_type   (vec_type)
    );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
    import irq_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_inta,
    input logic              bus_lock,
    input logic              load,
    input logic              intr_pin,
    input logic [WORD_W-1:0] flags_in
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bus_wr || bus_rd || bus_inta || bus_lock || load)); // R1

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_wr, bus_rd, bus_inta})); // R7

    AST_LOCK_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> bus_inta); // R6

    AST_ACK_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_inta) |=> (bus_inta && bus_lock)); // R6

    AST_ACK_NEEDS_IF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_inta) |-> $past(intr_pin && flags_in[IF_BIT])); // R5

    AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(bus_rd)); // R8

endmodule

bind irq_entry_seq irq_entry_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_inta (bus_inta),
    .bus_lock (bus_lock),
    .load     (load),
    .intr_pin (intr_pin),
    .flags_in (flags_in)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic instr_done = 0, exc_div = 0, exc_swi = 0, exc_into = 0, of_flag = 0;
    logic tf_at_start = 0, nmi_pin = 0, intr_pin = 0, iret_req = 0;
    logic [7:0]  swi_type = 0, inta_data = 0;
    logic [15:0] flags_in = 0, cs_in = 0, ip_in = 0, sp_in = 0, ss_in = 16'h1234;
    logic [15:0] rd_data;
    logic busy, bus_wr, bus_rd, bus_inta, bus_lock, load;
    logic [19:0] bus_addr;
    logic [15:0] wr_data, cs_out, ip_out, sp_out, flags_out;
    logic [7:0]  vec_type;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    irq_entry_seq i_irq_entry_seq (.*);

    function automatic logic [15:0] mem_word(input logic [19:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[19:16], 12'h000};
    endfunction

    function automatic logic [19:0] phys_b(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    always_comb rd_data = mem_word(bus_addr);

    // Transcript recorder: kind 0 = write, 1 = read, 2 = acknowledge
    int          n_log = 0;
    int          lg_kind [16];
    logic [19:0] lg_addr [16];
    logic [15:0] lg_data [16];
    logic        lg_lock [16];
    bit          seen_load = 0;
    logic [15:0] c_cs, c_ip, c_sp, c_fl;
    logic [7:0]  c_ty;

    always @(negedge clk) begin
        if (bus_wr || bus_rd || bus_inta) begin
            if (n_log < 16) begin
                lg_kind[n_log] = bus_wr ? 0 : (bus_rd ? 1 : 2);
                lg_addr[n_log] = bus_addr;
                lg_data[n_log] = bus_wr ? wr_data : (bus_rd ? rd_data : 16'h0);
                lg_lock[n_log] = bus_lock;
            end
            n_log++;
        end
        if (load) begin
            seen_load = 1;
            c_cs = cs_out; c_ip = ip_out; c_sp = sp_out; c_fl = flags_out; c_ty = vec_type;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic item(input int k, input int kind, input logic [19:0] a,
                        input logic [15:0] d, input string req);
        chk(lg_kind[k] == kind && lg_addr[k] == a && lg_data[k] == d, req,
            $sformatf("transfer %0d kind/addr/data", k),
            {lg_kind[k][3:0], lg_addr[k][11:0], lg_data[k]}, {kind[3:0], a[11:0], d});
    endtask

    task automatic wait_load();
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (seen_load) break;
        end
    endtask

    task automatic clear_log();
        n_log = 0;
        seen_load = 0;
    endtask

    // Full entry transcript against values derived from R6..R9
    task automatic check_entry(input logic [7:0] t, input bit ack, input string req);
        int b;
        b = ack ? 2 : 0;
        chk(seen_load, req, "load seen", {31'd0, seen_load}, 32'd1);
        chk(n_log == b + 5, "R7", "transfer count", n_log, b + 5);
        if (ack) begin
            chk(lg_kind[0] == 2 && lg_kind[1] == 2 && lg_lock[0] && lg_lock[1], "R6",
                "two locked acknowledges", {lg_kind[0][7:0], lg_kind[1][7:0], 7'd0, lg_lock[0], 7'd0, lg_lock[1]},
                32'h02020101);
        end
        if (n_log >= b + 5) begin
            item(b + 0, 0, phys_b(ss_in, sp_in - 16'd2), flags_in, "R7");
            item(b + 1, 0, phys_b(ss_in, sp_in - 16'd4), cs_in, "R7");
            item(b + 2, 0, phys_b(ss_in, sp_in - 16'd6), ip_in, "R7");
            item(b + 3, 1, {10'd0, t, 2'b00}, mem_word({10'd0, t, 2'b00}), "R8");
            item(b + 4, 1, {10'd0, t, 2'b10}, mem_word({10'd0, t, 2'b10}), "R8");
        end
        chk(c_ty == t, req, "vec_type", c_ty, t);
        chk(c_ip == mem_word({10'd0, t, 2'b00}) && c_cs == mem_word({10'd0, t, 2'b10}), "R8",
            "new CS:IP", {c_cs, c_ip}, {mem_word({10'd0, t, 2'b10}), mem_word({10'd0, t, 2'b00})});
        chk(c_sp == sp_in - 16'd6, "R9", "sp_out", c_sp, sp_in - 16'd6);
        chk(c_fl == (flags_in & 16'hFCFF), "R9", "flags_out", c_fl, flags_in & 16'hFCFF);
    endtask

    typedef struct packed {
        logic       div;
        logic       swi;
        logic       into;
        logic       ovf;
        logic       ifl;
        logic       tf;
        logic       nmi;
        logic       intr;
        logic [7:0] swi_t;
        logic [7:0] ack_t;
        logic       taken;
        logic [7:0] exp_t;
        logic       exp_ack;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VTAB [NV] = '{
        '{1,0,0,0,1,1,1,1,8'h00,8'h00,1,8'h00,0},   // R2 divide beats all
        '{0,0,0,0,1,1,1,1,8'h00,8'h00,1,8'h02,0},   // R2 R4 NMI beats INTR, step
        '{0,0,0,0,1,1,0,1,8'h00,8'h4A,1,8'h4A,1},   // R2 R6 INTR beats step
        '{0,0,0,0,0,1,0,0,8'h00,8'h00,1,8'h01,0},   // R10 step alone
        '{0,1,0,0,1,0,0,1,8'h21,8'h00,1,8'h21,0},   // R2 R3 software beats INTR
        '{0,1,0,0,0,0,0,0,8'h03,8'h00,1,8'h03,0},   // R3 breakpoint type
        '{0,0,1,1,0,0,0,0,8'h00,8'h00,1,8'h04,0},   // R3 overflow taken
        '{0,0,1,0,0,0,0,0,8'h00,8'h00,0,8'h00,0},   // R3 overflow clear: no entry
        '{0,0,0,0,0,0,0,1,8'h00,8'h00,0,8'h00,0},   // R5 masked INTR ignored
        '{0,0,0,0,0,1,0,1,8'h00,8'h00,1,8'h01,0},   // R10 masked INTR, step taken
        '{0,0,0,0,1,0,0,1,8'h00,8'hFF,1,8'hFF,1}    // R8 top table entry
    };

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vec_t v;
        // R1 during and after reset
        repeat (3) @(negedge clk);
        chk(!busy && !bus_wr && !bus_rd && !bus_inta && !bus_lock && !load, "R1",
            "quiet in reset", {26'd0, busy, bus_wr, bus_rd, bus_inta, bus_lock, load}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !bus_wr && !bus_rd && !bus_inta && !bus_lock && !load, "R1",
            "quiet after reset", {26'd0, busy, bus_wr, bus_rd, bus_inta, bus_lock, load}, 0);

        for (int i = 0; i < NV; i++) begin
            v = VTAB[i];
            flags_in    = 16'h09C5 | (v.ifl ? 16'h0200 : 16'h0000);
            cs_in       = 16'hC000 + 16'(i);
            ip_in       = 16'h0400 + 16'(i);
            sp_in       = 16'h0100 + 16'(i * 16);
            tf_at_start = v.tf;
            inta_data   = v.ack_t;
            if (v.nmi) begin
                nmi_pin = 1'b1;
                @(negedge clk);
                nmi_pin = 1'b0;
                @(negedge clk);
            end
            intr_pin = v.intr;
            clear_log();
            exc_div = v.div; exc_swi = v.swi; swi_type = v.swi_t;
            exc_into = v.into; of_flag = v.ovf; instr_done = 1'b1;
            @(negedge clk);
            exc_div = 0; exc_swi = 0; exc_into = 0; of_flag = 0; instr_done = 0;
            if (v.taken) begin
                wait_load();
                check_entry(v.exp_t, v.exp_ack, $sformatf("R2 row%0d", i));
            end else begin
                repeat (8) @(negedge clk);
                chk(n_log == 0 && !busy, (i == 7) ? "R3" : "R5",
                    $sformatf("row%0d no entry", i), n_log, 0);
            end
            intr_pin = 0; tf_at_start = 0;
            repeat (2) @(negedge clk);
        end

        // R12: a boundary while busy is ignored
        flags_in = 16'h0200; cs_in = 16'hA000; ip_in = 16'h0010; sp_in = 16'h0300;
        clear_log();
        exc_div = 1; instr_done = 1;
        @(negedge clk);
        exc_div = 0; instr_done = 0;
        @(negedge clk);
        exc_swi = 1; swi_type = 8'h33; instr_done = 1; iret_req = 1;
        @(negedge clk);
        exc_swi = 0; instr_done = 0; iret_req = 0;
        wait_load();
        repeat (8) @(negedge clk);
        chk(n_log == 5, "R12", "transfers after busy pulse", n_log, 5);
        chk(c_ty == 8'h00, "R12", "type after busy pulse", c_ty, 0);

        // R4: NMI edge during a software entry is held and taken later
        clear_log();
        exc_swi = 1; swi_type = 8'h40; instr_done = 1;
        @(negedge clk);
        exc_swi = 0; instr_done = 0; nmi_pin = 1;
        @(negedge clk);
        nmi_pin = 0;
        wait_load();
        chk(c_ty == 8'h40, "R4", "entry in progress keeps its type", c_ty, 8'h40);
        repeat (3) @(negedge clk);
        clear_log();
        instr_done = 1;
        @(negedge clk);
        instr_done = 0;
        wait_load();
        check_entry(8'h02, 1'b0, "R4");
        repeat (3) @(negedge clk);
        clear_log();
        instr_done = 1;
        @(negedge clk);
        instr_done = 0;
        repeat (8) @(negedge clk);
        chk(n_log == 0, "R4", "NMI cleared once serviced", n_log, 0);

        // R11: return pops IP, CS, FLAGS
        sp_in = 16'h0200;
        clear_log();
        iret_req = 1;
        @(negedge clk);
        iret_req = 0;
        wait_load();
        chk(n_log == 3, "R11", "pop count", n_log, 3);
        if (n_log >= 3) begin
            item(0, 1, phys_b(ss_in, 16'h0200), mem_word(phys_b(ss_in, 16'h0200)), "R11");
            item(1, 1, phys_b(ss_in, 16'h0202), mem_word(phys_b(ss_in, 16'h0202)), "R11");
            item(2, 1, phys_b(ss_in, 16'h0204), mem_word(phys_b(ss_in, 16'h0204)), "R11");
        end
        chk(c_ip == mem_word(phys_b(ss_in, 16'h0200)), "R11", "ip_out", c_ip,
            mem_word(phys_b(ss_in, 16'h0200)));
        chk(c_cs == mem_word(phys_b(ss_in, 16'h0202)), "R11", "cs_out", c_cs,
            mem_word(phys_b(ss_in, 16'h0202)));
        chk(c_fl == mem_word(phys_b(ss_in, 16'h0204)), "R11", "flags_out", c_fl,
            mem_word(phys_b(ss_in, 16'h0204)));
        chk(c_sp == 16'h0206, "R11", "sp_out", c_sp, 16'h0206);
        repeat (2) @(negedge clk);
        chk(!busy, "R1", "idle after return", {31'd0, busy}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule